// File: doc/BRIEF.md
# Host-Bridge CPU Address Decoder

This block sits on the CPU side of a host bridge. Each CPU request carries an address, a byte count (1, 2 or 4), a read/write flag and write data. The block sorts the request into one of several target windows: the I/O window, the direct configuration window, the interrupt-acknowledge byte or the PCI memory window. It then forwards one downstream request that carries a target code and a translated address. In the I/O window a mode pin picks between a plain 64 KB space and a sparse 8 MB layout. Inside the I/O space the two configuration port addresses get target codes of their own.

Interrupt-acknowledge reads and requests that hit no window are finished inside the block. These produce a one-cycle local completion and do not go downstream. A request that hits no window also raises a one-cycle decode-error pulse. The block also merges the four interrupt pins of every slot onto two interrupt outputs by a rotating rule.

Both request interfaces use valid/ready, and one register stage sits between them. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Its result shows up after that edge. While a downstream result waits with `dn_valid` high and `dn_ready` low, the result holds steady and `req_ready` stays low. A local completion never stalls the input.

Top module: `hb_addr_decoder`

## Requirements
- R1: `req_ready` is high after reset and is low only while a downstream result is held with `dn_ready` low. The result of an accepted request appears one cycle after acceptance and stays unchanged until `dn_ready` is seen high.
- R2: Addresses 0xC0000000 to 0xFEFFFFFF go downstream with target code 5, and `dn_addr` = address − 0xC0000000.
- R3: Addresses 0x80000000 to 0xBF7FFFFF outside the configuration window go downstream as I/O (code 1). With offset = address − 0x80000000, `dn_addr` = offset & 0xFFFF in mode 0. In mode 1 the same rule applies when offset ≥ 0x800000.
- R4: In mode 1 (`io_sparse` = 1), an I/O offset below 0x800000 is translated to (offset & 0x1F) | ((offset & 0x7FFF000) >> 7).
- R5: The mode pin is sampled on the acceptance edge. Changing it afterwards does not alter the held result.
- R6: Addresses 0x80800000 to 0x80BFFFFF go downstream with target code 2, and `dn_addr` = address & 0x7FF.
- R7: An I/O access whose translated address lies in 0xCF8..0xCFB gets target code 3. One whose translated address lies in 0xCFC..0xCFF gets code 4. `dn_addr` carries the translated address.
- R8: A 1-byte read of 0xBFFFFFF0 is completed locally. `lcl_done` pulses one cycle after acceptance, and `lcl_rdata` equals `iack_vector` as sampled at acceptance, zero-extended. Any other size, or a write, at that address is a decode error.
- R9: An address that hits no window is completed locally with `lcl_done` and `dec_err` pulsing one cycle after acceptance. `lcl_rdata` is 0xFFFFFFFF and `dn_valid` stays low.
- R10: A size other than 1, 2 or 4 is a decode error (as in R9) at any address.
- R11: `dn_size`, `dn_write` and `dn_wdata` equal the accepted request's values, and no alignment check is made.
- R12: `irq_out[k]` is the OR of every pin n of slot s (bit s*4+n of `slot_intx`) with (n + s) & 1 = k. The output is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_sparse | input | 1 | I/O layout mode: 0 plain, 1 sparse |
| req_valid | input | 1 | CPU request valid |
| req_ready | output | 1 | CPU request ready |
| req_addr | input | 32 | CPU address |
| req_size | input | 3 | Byte count (1, 2, 4 legal) |
| req_write | input | 1 | 1 = write |
| req_wdata | input | 32 | Write data |
| iack_vector | input | 8 | Vector returned on acknowledge reads |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream ready |
| dn_target | output | 3 | Target code |
| dn_addr | output | 32 | Translated address |
| dn_size | output | 3 | Byte count |
| dn_write | output | 1 | Write flag |
| dn_wdata | output | 32 | Write data |
| lcl_done | output | 1 | Local completion pulse |
| lcl_rdata | output | 32 | Local read data |
| dec_err | output | 1 | Decode-error pulse |
| slot_intx | input | 16 | Interrupt pins, four per slot |
| irq_out | output | 2 | Routed interrupt outputs |

## Verification
The assertions check the following on every cycle:
- a result held under back-pressure stays stable;
- a held result blocks the input;
- an error pulse never comes with a downstream request;
- memory-window and configuration-window translations match the accepted address;
- the sparse low bits survive.

The bench scenarios cover the rest:
- the exact window boundaries;
- the sparse packing of upper bits;
- the configuration-port codes reached through both I/O layouts;
- the acknowledge vector;
- mode changes made after acceptance;
- the rotating interrupt mapping across random pin patterns.

// File: rtl/hbd_pkg.sv
package hbd_pkg;
  typedef enum logic [2:0] {
    TGT_NONE       = 3'd0,
    TGT_IO         = 3'd1,
    TGT_CFG_DIRECT = 3'd2,
    TGT_CFG_ADDR   = 3'd3,
    TGT_CFG_DATA   = 3'd4,
    TGT_MEM        = 3'd5
  } tgt_e;

  localparam logic [31:0] IO_BASE     = 32'h8000_0000;
  localparam logic [31:0] IO_LAST     = 32'hBF7F_FFFF;
  localparam logic [31:0] CFG_BASE    = 32'h8080_0000;
  localparam logic [31:0] CFG_LAST    = 32'h80BF_FFFF;
  localparam logic [31:0] IACK_ADDR   = 32'hBFFF_FFF0;
  localparam logic [31:0] MEM_BASE    = 32'hC000_0000;
  localparam logic [31:0] MEM_LAST    = 32'hFEFF_FFFF;
  localparam logic [31:0] SPARSE_SPAN = 32'h0080_0000;
  localparam int          CFG_OFS_W   = 11;
  localparam int          PORT_W      = 16;
  localparam logic [15:0] PORT_CADDR  = 16'h0CF8;
  localparam logic [15:0] PORT_CDATA  = 16'h0CFC;

  typedef struct packed {
    logic        is_local;
    logic        err;
    tgt_e        tgt;
    logic [31:0] addr;
  } dec_t;
endpackage

// File: rtl/hbd_io_xlate.sv
module hbd_io_xlate
  import hbd_pkg::*;
#(
  parameter int LOW_BITS   = 5,
  parameter int SHIFT_FROM = 12
) (
  input  logic [31:0]       offset,
  input  logic              sparse,
  output logic [PORT_W-1:0] io_addr,
  output tgt_e              tgt
);
  logic              sparse_hit;
  logic [PORT_W-1:0] packed_addr;

  assign sparse_hit = sparse && (offset < SPARSE_SPAN);

  for (genvar i = 0; i < PORT_W; i++) begin : g_pack
    if (i < LOW_BITS) begin : g_low
      assign packed_addr[i] = offset[i];
    end else begin : g_high
      assign packed_addr[i] = offset[i - LOW_BITS + SHIFT_FROM];
    end
  end

  always_comb begin
    io_addr = sparse_hit ? packed_addr : offset[PORT_W-1:0];
    if (io_addr[PORT_W-1:2] == PORT_CADDR[PORT_W-1:2])      tgt = TGT_CFG_ADDR;
    else if (io_addr[PORT_W-1:2] == PORT_CDATA[PORT_W-1:2]) tgt = TGT_CFG_DATA;
    else                                                   tgt = TGT_IO;
  end
endmodule

// File: rtl/hbd_window_decode.sv
module hbd_window_decode
  import hbd_pkg::*;
(
  input  logic [31:0] addr,
  input  logic [2:0]  size,
  input  logic        write,
  input  logic        sparse,
  output dec_t        dec
);
  logic [31:0]       io_off;
  logic [PORT_W-1:0] io_addr;
  tgt_e              io_tgt;
  logic              size_ok;

  assign io_off  = addr - IO_BASE;
  assign size_ok = (size == 3'd1) || (size == 3'd2) || (size == 3'd4);

  hbd_io_xlate u_io (
    .offset (io_off),
    .sparse (sparse),
    .io_addr(io_addr),
    .tgt    (io_tgt)
  );

  always_comb begin
    dec = '{is_local: 1'b1, err: 1'b1, tgt: TGT_NONE, addr: '0};
    if (!size_ok) begin
      dec.err = 1'b1;
    end else if (addr == IACK_ADDR) begin
      dec.err = write || (size != 3'd1);
    end else if (addr >= CFG_BASE && addr <= CFG_LAST) begin
      dec = '{is_local: 1'b0, err: 1'b0, tgt: TGT_CFG_DIRECT,
              addr: {{(32-CFG_OFS_W){1'b0}}, addr[CFG_OFS_W-1:0]}};
    end else if (addr >= IO_BASE && addr <= IO_LAST) begin
      dec = '{is_local: 1'b0, err: 1'b0, tgt: io_tgt,
              addr: {{(32-PORT_W){1'b0}}, io_addr}};
    end else if (addr >= MEM_BASE && addr <= MEM_LAST) begin
      dec = '{is_local: 1'b0, err: 1'b0, tgt: TGT_MEM, addr: addr - MEM_BASE};
    end
  end
endmodule

// File: rtl/hbd_irq_route.sv
module hbd_irq_route #(
  parameter int NUM_SLOTS = 4,
  localparam int PINS     = 4,
  localparam int IN_W     = NUM_SLOTS * PINS
) (
  input  logic [IN_W-1:0] pins,
  output logic [1:0]      irq_out
);
  logic [1:0] slot_or [NUM_SLOTS];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    if ((s % 2) == 0) begin : g_even
      assign slot_or[s][0] = pins[s*PINS+0] | pins[s*PINS+2];
      assign slot_or[s][1] = pins[s*PINS+1] | pins[s*PINS+3];
    end else begin : g_odd
      assign slot_or[s][1] = pins[s*PINS+0] | pins[s*PINS+2];
      assign slot_or[s][0] = pins[s*PINS+1] | pins[s*PINS+3];
    end
  end

  always_comb begin
    irq_out = '0;
    for (int s = 0; s < NUM_SLOTS; s++) irq_out |= slot_or[s];
  end

  // R12: no pin active means both outputs quiet
  always_comb begin
    if (pins == '0) a_r12_quiet: assert (irq_out == 2'b00);
  end
endmodule

// File: rtl/hbd_out_stage.sv
module hbd_out_stage
  import hbd_pkg::*;
#(
  parameter int DW    = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  dec_t             in_dec,
  input  logic [2:0]       in_size,
  input  logic             in_write,
  input  logic [DW-1:0]    in_wdata,
  input  logic [VEC_W-1:0] in_vec,
  output logic             dn_valid,
  input  logic             dn_ready,
  output tgt_e             dn_target,
  output logic [31:0]      dn_addr,
  output logic [2:0]       dn_size,
  output logic             dn_write,
  output logic [DW-1:0]    dn_wdata,
  output logic             lcl_done,
  output logic [DW-1:0]    lcl_rdata,
  output logic             dec_err
);
  logic full, loc, err;
  logic accept;

  assign in_ready = !full || loc || dn_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full      <= 1'b0;
      loc       <= 1'b0;
      err       <= 1'b0;
      dn_target <= TGT_NONE;
      dn_addr   <= '0;
      dn_size   <= '0;
      dn_write  <= 1'b0;
      dn_wdata  <= '0;
      lcl_rdata <= '0;
    end else if (accept) begin
      full      <= 1'b1;
      loc       <= in_dec.is_local;
      err       <= in_dec.err;
      dn_target <= in_dec.tgt;
      dn_addr   <= in_dec.addr;
      dn_size   <= in_size;
      dn_write  <= in_write;
      dn_wdata  <= in_wdata;
      lcl_rdata <= in_dec.err ? {DW{1'b1}} : {{(DW-VEC_W){1'b0}}, in_vec};
    end else if (full && (loc || dn_ready)) begin
      full <= 1'b0;
    end
  end

  assign dn_valid = full && !loc;
  assign lcl_done = full && loc;
  assign dec_err  = full && loc && err;

  // R1: a stalled downstream result holds every field
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && !dn_ready |=> dn_valid && $stable(dn_addr) && $stable(dn_target)
      && $stable(dn_wdata) && $stable(dn_size) && $stable(dn_write));
endmodule

// File: rtl/hb_addr_decoder.sv
module hb_addr_decoder
  import hbd_pkg::*;
#(
  parameter int DW        = 32,
  parameter int VEC_W     = 8,
  parameter int NUM_SLOTS = 4,
  localparam int INTX_W   = NUM_SLOTS * 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_sparse,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_addr,
  input  logic [2:0]        req_size,
  input  logic              req_write,
  input  logic [DW-1:0]     req_wdata,
  input  logic [VEC_W-1:0]  iack_vector,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [2:0]        dn_target,
  output logic [31:0]       dn_addr,
  output logic [2:0]        dn_size,
  output logic              dn_write,
  output logic [DW-1:0]     dn_wdata,
  output logic              lcl_done,
  output logic [DW-1:0]     lcl_rdata,
  output logic              dec_err,
  input  logic [INTX_W-1:0] slot_intx,
  output logic [1:0]        irq_out
);
  dec_t dec;
  tgt_e tgt_q;

  hbd_window_decode u_dec (
    .addr  (req_addr),
    .size  (req_size),
    .write (req_write),
    .sparse(io_sparse),
    .dec   (dec)
  );

  hbd_out_stage #(.DW(DW), .VEC_W(VEC_W)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (req_valid),
    .in_ready (req_ready),
    .in_dec   (dec),
    .in_size  (req_size),
    .in_write (req_write),
    .in_wdata (req_wdata),
    .in_vec   (iack_vector),
    .dn_valid (dn_valid),
    .dn_ready (dn_ready),
    .dn_target(tgt_q),
    .dn_addr  (dn_addr),
    .dn_size  (dn_size),
    .dn_write (dn_write),
    .dn_wdata (dn_wdata),
    .lcl_done (lcl_done),
    .lcl_rdata(lcl_rdata),
    .dec_err  (dec_err)
  );

  assign dn_target = tgt_q;

  hbd_irq_route #(.NUM_SLOTS(NUM_SLOTS)) u_irq (
    .pins   (slot_intx),
    .irq_out(irq_out)
  );

  logic acc, size_ok;
  assign acc     = req_valid && req_ready;
  assign size_ok = (req_size == 3'd1) || (req_size == 3'd2) || (req_size == 3'd4);

  // R1: a held downstream result blocks new requests
  a_r1_block: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && !dn_ready |-> !req_ready);

  // R9: an error pulse is a local completion, never a downstream request
  a_r9_err_local: assert property (@(posedge clk) disable iff (!rst_n)
    dec_err |-> lcl_done && !dn_valid);

  // R2: memory window translation
  a_r2_mem: assert property (@(posedge clk) disable iff (!rst_n)
    acc && size_ok && req_addr >= MEM_BASE && req_addr <= MEM_LAST |=>
      dn_valid && dn_target == 3'd5 && dn_addr == $past(req_addr) - MEM_BASE);

  // R6: direct configuration window keeps the low offset
  a_r6_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    acc && size_ok && req_addr >= CFG_BASE && req_addr <= CFG_LAST |=>
      dn_valid && dn_target == 3'd2 && dn_addr == {21'd0, $past(req_addr[10:0])});

  // R4: sparse layout keeps the five low offset bits
  a_r4_sparse_low: assert property (@(posedge clk) disable iff (!rst_n)
    acc && size_ok && io_sparse && req_addr >= IO_BASE && req_addr < IO_BASE + SPARSE_SPAN |=>
      dn_valid && dn_addr[4:0] == $past(req_addr[4:0]));
endmodule

// File: tb/test_hb_addr_decoder.sv
module test_hb_addr_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_sparse = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [2:0]  req_size = 3'd1;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic [7:0]  iack_vector = '0;
  logic        dn_valid;
  logic        dn_ready = 1'b1;
  logic [2:0]  dn_target;
  logic [31:0] dn_addr;
  logic [2:0]  dn_size;
  logic        dn_write;
  logic [31:0] dn_wdata;
  logic        lcl_done;
  logic [31:0] lcl_rdata;
  logic        dec_err;
  logic [15:0] slot_intx = '0;
  logic [1:0]  irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hb_addr_decoder i_hb_addr_decoder (.*);

  typedef struct packed {
    logic        loc;
    logic        err;
    logic [2:0]  tgt;
    logic [31:0] addr;
  } exp_t;

  function automatic exp_t model(input logic [31:0] a, input logic [2:0] sz,
                                 input logic wr, input logic md);
    exp_t e = '{loc: 1'b1, err: 1'b1, tgt: 3'd0, addr: 32'd0};
    logic [31:0] off, x;
    if (!(sz == 3'd1 || sz == 3'd2 || sz == 3'd4)) return e;
    if (a == 32'hBFFF_FFF0) begin
      e.err = wr || (sz != 3'd1);
      return e;
    end
    if (a >= 32'h8080_0000 && a <= 32'h80BF_FFFF) begin
      e = '{loc: 1'b0, err: 1'b0, tgt: 3'd2, addr: a & 32'h7FF};
    end else if (a >= 32'h8000_0000 && a <= 32'hBF7F_FFFF) begin
      off = a - 32'h8000_0000;
      if (md && off < 32'h0080_0000) x = (off & 32'h1F) | ((off & 32'h07FF_F000) >> 7);
      else                           x = off & 32'hFFFF;
      e = '{loc: 1'b0, err: 1'b0, tgt: 3'd1, addr: x};
      if (x >= 32'hCF8 && x <= 32'hCFB) e.tgt = 3'd3;
      if (x >= 32'hCFC && x <= 32'hCFF) e.tgt = 3'd4;
    end else if (a >= 32'hC000_0000 && a <= 32'hFEFF_FFFF) begin
      e = '{loc: 1'b0, err: 1'b0, tgt: 3'd5, addr: a - 32'hC000_0000};
    end
    return e;
  endfunction

  function automatic string tag_of(input exp_t e, input logic md, input logic [31:0] a);
    if (e.loc) return e.err ? "R9/R10" : "R8";
    case (e.tgt)
      3'd2: return "R6";
      3'd3, 3'd4: return "R7";
      3'd5: return "R2";
      default: return (md && a < 32'h8080_0000) ? "R4" : "R3";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_req(input logic [31:0] a, input logic [2:0] sz,
                        input logic wr, input logic md);
    exp_t e;
    string t;
    logic [7:0] vec = 8'($urandom);
    logic [31:0] wd = $urandom;
    @(negedge clk);
    req_addr = a; req_size = sz; req_write = wr; req_wdata = wd;
    io_sparse = md; iack_vector = vec; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    io_sparse = ~md;
    iack_vector = ~vec;
    e = model(a, sz, wr, md);
    t = tag_of(e, md, a);
    if (e.loc) begin
      check({t, " local done"}, 32'(lcl_done), 32'd1);
      check({t, " error pulse"}, 32'(dec_err), 32'(e.err));
      check({t, " no downstream"}, 32'(dn_valid), 32'd0);
      if (!wr) check({t, " local data"}, lcl_rdata, e.err ? 32'hFFFF_FFFF : {24'd0, vec});
    end else begin
      check({t, " dn_valid"}, 32'(dn_valid), 32'd1);
      check({t, " target"}, 32'(dn_target), 32'(e.tgt));
      check({t, " R5 address"}, dn_addr, e.addr);
      check({t, " no error"}, 32'(dec_err | lcl_done), 32'd0);
      check("R11 size", 32'(dn_size), 32'(sz));
      check("R11 write", 32'(dn_write), 32'(wr));
      check("R11 wdata", dn_wdata, wd);
    end
  endtask

  function automatic logic [1:0] irq_model(input logic [15:0] p);
    logic [1:0] r = 2'b00;
    for (int s = 0; s < 4; s++)
      for (int n = 0; n < 4; n++)
        if (p[s*4+n]) r[(n + s) & 1] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] rand_addr();
    case ($urandom % 7)
      0: return 32'h8000_0000 + ($urandom % 32'h0080_0000);
      1: return 32'h8080_0000 + ($urandom % 32'h0040_0000);
      2: return 32'h8000_0000 + ($urandom % 32'h3F80_0000);
      3: return 32'hC000_0000 + ($urandom % 32'h3F00_0000);
      4: return $urandom % 32'h8000_0000;
      5: return 32'hBFFF_FFF0;
      default: return 32'h8000_0CF8 + ($urandom % 8);
    endcase
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset dn_valid", 32'(dn_valid), 32'd0);
    check("R1 reset lcl_done", 32'(lcl_done), 32'd0);
    check("R9 reset dec_err", 32'(dec_err), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", 32'(req_ready), 32'd1);

    // directed window boundaries
    do_req(32'h7FFF_FFFF, 3'd4, 1'b0, 1'b0);
    do_req(32'h8000_0000, 3'd1, 1'b0, 1'b0);
    do_req(32'h8000_1234, 3'd2, 1'b0, 1'b1);
    do_req(32'h807F_FFFF, 3'd4, 1'b1, 1'b1);
    do_req(32'h8080_0000, 3'd4, 1'b0, 1'b1);
    do_req(32'h80BF_FFFF, 3'd1, 1'b1, 1'b0);
    do_req(32'h80C1_2345, 3'd2, 1'b0, 1'b1);
    do_req(32'hBF7F_FFFF, 3'd1, 1'b0, 1'b0);
    do_req(32'hBF80_0000, 3'd1, 1'b0, 1'b0);
    do_req(32'h8000_0CF8, 3'd4, 1'b1, 1'b0);
    do_req(32'h8000_0CFD, 3'd1, 1'b0, 1'b0);
    do_req(32'h8006_7018, 3'd4, 1'b1, 1'b1);
    do_req(32'h8006_701C, 3'd4, 1'b0, 1'b1);
    do_req(32'hBFFF_FFF0, 3'd1, 1'b0, 1'b0);
    do_req(32'hBFFF_FFF0, 3'd2, 1'b0, 1'b0);
    do_req(32'hBFFF_FFF0, 3'd1, 1'b1, 1'b0);
    do_req(32'hC000_0000, 3'd4, 1'b0, 1'b0);
    do_req(32'hFEFF_FFFF, 3'd1, 1'b1, 1'b0);
    do_req(32'hFF00_0000, 3'd4, 1'b0, 1'b0);
    do_req(32'hC000_0003, 3'd3, 1'b0, 1'b0);
    do_req(32'h8000_0010, 3'd0, 1'b1, 1'b0);
    do_req(32'hC123_4567, 3'd4, 1'b1, 1'b0);

    // R1 back-pressure
    @(negedge clk);
    dn_ready = 1'b0;
    req_addr = 32'hC000_1000; req_size = 3'd4; req_write = 1'b1;
    req_wdata = 32'hA5A5_0001; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_addr = 32'hC000_2000;
    for (int k = 0; k < 3; k++) begin
      check("R1 stall ready low", 32'(req_ready), 32'd0);
      check("R1 stall holds addr", dn_addr, 32'h0000_1000);
      @(negedge clk);
    end
    dn_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R1 next after release", dn_addr, 32'h0000_2000);

    // constrained random traffic
    for (int i = 0; i < 300; i++) begin
      logic [2:0] sz;
      case ($urandom % 8)
        0: sz = 3'($urandom);
        1, 2: sz = 3'd1;
        3, 4: sz = 3'd2;
        default: sz = 3'd4;
      endcase
      do_req(rand_addr(), sz, 1'($urandom), 1'($urandom));
    end

    // R12 interrupt routing
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      slot_intx = 16'd1 << i;
      #1 check("R12 single pin", 32'(irq_out), 32'(irq_model(slot_intx)));
    end
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      slot_intx = 16'($urandom) & 16'($urandom);
      #1 check("R12 random pins", 32'(irq_out), 32'(irq_model(slot_intx)));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule